// File: doc/BRIEF.md
# Quantizer Sample Slice Serializer

The block takes four one-bit quantizer outputs per sample (I sign, I magnitude, Q sign, Q magnitude) and turns them into a single serial bit stream on a fast serial clock. A one-cycle strobe marks each new sample. Each of the four bits is gathered into its own 16-sample register. When the 16th sample of a period arrives, the whole group is handed to a second set of registers. During the next sample period those registers are emitted one channel slice after another, with the oldest sample first. Only the channels picked by a two-bit select are emitted. After the last selected slice the line stays low. A one-cycle marker flags the first bit of every slice, and a separate timing marker fires once every programmable number of accepted samples.

The sample side has no back-pressure: a strobe is accepted on every cycle in which the stream is enabled and no clear is applied. The output side has no ready input. The integrator must therefore run the serial clock fast enough: 16 cycles per selected channel for each 16-sample period, which is at least twice the sample rate for two channels and four times for four. If a new group completes before the previous one has drained, the new group replaces it at once. A synchronous clear returns every counter to its start point in the cycle it is applied.

Top module: `sample_stream_packer`

## Requirements
- R1: After reset, `ser_data`, `data_sync` and `time_sync` are low, and they stay low until a slice or a time pulse is produced.
- R2: `smp_bits[0]` is I sign, `[1]` is I magnitude, `[2]` is Q sign and `[3]` is Q magnitude. Within a slice, a channel's 16 samples leave in arrival order, oldest first.
- R3: The accepting edge of the 16th sample of a period transfers the group. The first bit of the first slice appears on `ser_data` in the cycle that follows that edge, and each later bit follows one cycle after the previous one.
- R4: `chan_sel` encoding: 00 emits channel 0 only; 01 emits 0 then 1; 10 emits 0 then 2; 11 emits 0, 1, 2, 3 in that order. The select is captured at the transfer edge, so a change affects only later groups.
- R5: When all selected slices of a group have been sent, `ser_data` is 0 until the next group starts.
- R6: `data_sync` is high for exactly one cycle, together with the first bit of every slice, and is low at all other times.
- R7: `time_sync` is a one-cycle pulse. It is high in the cycle after each N-th accepted strobe, where N is the effective period and the count runs from reset or clear.
- R8: The effective period is `ts_period` clamped to the range 128 to 16384. Change the period only together with a clear.
- R9: A cycle with `stream_clr` high discards any strobe in that cycle. It zeroes the sample, slice and time counters and stops any slice in progress, so that all three outputs are low in the next cycle.
- R10: A strobe while `stream_en` is low is ignored: it advances neither the sample count nor the time count.
- R11: A group that completes while the previous group is still being sent restarts emission at once with the new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle sample strobe |
| smp_bits | input | 4 | Sample bits: I sign, I magnitude, Q sign, Q magnitude (bit 0 to 3) |
| chan_sel | input | 2 | Streamed channel set select |
| stream_en | input | 1 | Accept strobes when high |
| stream_clr | input | 1 | Synchronous counter clear |
| ts_period | input | 15 | Time-sync period in accepted samples |
| ser_data | output | 1 | Serial data |
| data_sync | output | 1 | First-bit marker of each slice |
| time_sync | output | 1 | Periodic timing marker |

## Verification
The hardest case to reach is overlap between groups. A new transfer must land while the previous group's slices are still leaving, and a select change must arrive in the middle of a group. The bench gets there by running four-channel streaming with a strobe on every serial cycle, which forces restarts. It also switches `chan_sel` between phases without a clear, so that a group already captured drains under the old select. The time counter's upper clamp needs over sixteen thousand accepted strobes, so one long phase runs with a strobe every cycle and a requested period above the maximum.

// File: rtl/ssp_pkg.sv
`timescale 1ns/100ps
package ssp_pkg;
  localparam int NUM_CH = 4;

  typedef enum logic [1:0] {
    SEL_ONE  = 2'b00,
    SEL_IPAIR = 2'b01,
    SEL_SIGNS = 2'b10,
    SEL_ALL  = 2'b11
  } chan_sel_e;

  // channel emitted in a given slot of a group
  function automatic logic [1:0] slot_chan(input chan_sel_e sel, input logic [1:0] slot);
    logic [1:0] ch;
    if (slot == 2'd0)          ch = 2'd0;
    else if (sel == SEL_ALL)   ch = slot;
    else if (sel == SEL_IPAIR) ch = 2'd1;
    else                       ch = 2'd2;
    return ch;
  endfunction

  function automatic logic [1:0] last_slot(input chan_sel_e sel);
    logic [1:0] ls;
    case (sel)
      SEL_ONE: ls = 2'd0;
      SEL_ALL: ls = 2'd3;
      default: ls = 2'd1;
    endcase
    return ls;
  endfunction
endpackage

// File: rtl/ssp_collector.sv
`timescale 1ns/100ps
module ssp_collector
  import ssp_pkg::*;
#(
  parameter int SLICE_LEN = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clr,
  input  logic                               smp_valid,
  input  logic                               stream_en,
  input  logic [NUM_CH-1:0]                  bits_in,
  output logic                               accept,
  output logic                               load,
  output logic [NUM_CH-1:0][SLICE_LEN-1:0]   slice
);
  localparam int CW = $clog2(SLICE_LEN);
  localparam logic [CW-1:0] LAST = CW'(SLICE_LEN - 1);

  logic [CW-1:0]        idx;
  logic [SLICE_LEN-1:0] hold [NUM_CH];

  assign accept = smp_valid && stream_en && !clr;
  assign load   = accept && (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (clr)    idx <= '0;
    else if (accept) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept)
      for (int c = 0; c < NUM_CH; c++) hold[c][idx] <= bits_in[c];
  end

  // group image including the sample arriving this cycle
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      slice[c]       = hold[c];
      slice[c][LAST] = bits_in[c];
    end
  end

  a_r10_idle_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!stream_en && !clr) |=> $stable(idx));
  a_r9_clear_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == '0));
endmodule

// File: rtl/ssp_serializer.sv
`timescale 1ns/100ps
module ssp_serializer
  import ssp_pkg::*;
#(
  parameter int SLICE_LEN = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clr,
  input  logic                               load,
  input  logic [NUM_CH-1:0][SLICE_LEN-1:0]   slice,
  input  logic [1:0]                         sel,
  output logic                               ser_data,
  output logic                               data_sync
);
  localparam int CW = $clog2(SLICE_LEN);
  localparam logic [CW-1:0] LAST = CW'(SLICE_LEN - 1);

  logic                 active;
  logic [1:0]           slot;
  logic [CW-1:0]        bitc;
  chan_sel_e            sel_q;
  logic [SLICE_LEN-1:0] sh [NUM_CH];
  logic [1:0]           cur_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      slot   <= '0;
      bitc   <= '0;
      sel_q  <= SEL_ONE;
    end else if (clr) begin
      active <= 1'b0;
      slot   <= '0;
      bitc   <= '0;
    end else if (load) begin
      active <= 1'b1;
      slot   <= '0;
      bitc   <= '0;
      sel_q  <= chan_sel_e'(sel);
    end else if (active) begin
      bitc <= bitc + 1'b1;
      if (bitc == LAST) begin
        if (slot == last_slot(sel_q)) active <= 1'b0;
        else                          slot   <= slot + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load)
      for (int c = 0; c < NUM_CH; c++) sh[c] <= slice[c];
  end

  assign cur_ch    = slot_chan(sel_q, slot);
  assign ser_data  = active && sh[cur_ch][bitc];
  assign data_sync = active && (bitc == '0);

  a_r3_group_starts_next: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> data_sync);
  a_r6_sync_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    data_sync |=> !data_sync);
  a_r5_tail_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bitc == LAST && slot == last_slot(sel_q) && !load && !clr)
      |=> (!ser_data && !data_sync));
  a_r9_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ser_data && !data_sync));
endmodule

// File: rtl/ssp_tsync.sv
`timescale 1ns/100ps
module ssp_tsync #(
  parameter int TS_MIN = 128,
  parameter int TS_MAX = 16384,
  localparam int TW = $clog2(TS_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          accept,
  input  logic [TW-1:0] period,
  output logic          pulse
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] lim;

  always_comb begin
    if (period < TW'(TS_MIN))      lim = TW'(TS_MIN);
    else if (period > TW'(TS_MAX)) lim = TW'(TS_MAX);
    else                           lim = period;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (clr) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (accept) begin
        if (cnt >= lim - 1'b1) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  a_r7_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(accept));
  a_r9_clear_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pulse);
endmodule

// File: rtl/sample_stream_packer.sv
`timescale 1ns/100ps
module sample_stream_packer
  import ssp_pkg::*;
#(
  parameter int SLICE_LEN = 16,
  parameter int TS_MIN    = 128,
  parameter int TS_MAX    = 16384,
  localparam int TW       = $clog2(TS_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [NUM_CH-1:0] smp_bits,
  input  logic [1:0]        chan_sel,
  input  logic              stream_en,
  input  logic              stream_clr,
  input  logic [TW-1:0]     ts_period,
  output logic              ser_data,
  output logic              data_sync,
  output logic              time_sync
);
  logic                             accept;
  logic                             load;
  logic [NUM_CH-1:0][SLICE_LEN-1:0] slice;

  ssp_collector #(.SLICE_LEN(SLICE_LEN)) u_col (
    .clk(clk), .rst_n(rst_n), .clr(stream_clr), .smp_valid(smp_valid),
    .stream_en(stream_en), .bits_in(smp_bits), .accept(accept),
    .load(load), .slice(slice)
  );

  ssp_serializer #(.SLICE_LEN(SLICE_LEN)) u_ser (
    .clk(clk), .rst_n(rst_n), .clr(stream_clr), .load(load), .slice(slice),
    .sel(chan_sel), .ser_data(ser_data), .data_sync(data_sync)
  );

  ssp_tsync #(.TS_MIN(TS_MIN), .TS_MAX(TS_MAX)) u_ts (
    .clk(clk), .rst_n(rst_n), .clr(stream_clr), .accept(accept),
    .period(ts_period), .pulse(time_sync)
  );

  a_r10_off_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!stream_en) |=> !time_sync);
endmodule

// File: tb/sample_stream_packer_test.sv
`timescale 1ns/100ps
module sample_stream_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [3:0]  smp_bits = '0;
  logic [1:0]  chan_sel = 2'b11;
  logic        stream_en = 1'b0;
  logic        stream_clr = 1'b0;
  logic [14:0] ts_period = 15'd128;
  logic        ser_data, data_sync, time_sync;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // requirement model state
  logic [15:0] cur [4];
  logic [15:0] snap [4];
  logic [1:0]  sel_snap = 2'b00;
  int idx = 0, tc = 0, per_eff = 128, since = 100000;
  logic exp_ts = 1'b0;

  always #2.5 clk = ~clk;

  sample_stream_packer uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bits(smp_bits),
    .chan_sel(chan_sel), .stream_en(stream_en), .stream_clr(stream_clr),
    .ts_period(ts_period), .ser_data(ser_data), .data_sync(data_sync),
    .time_sync(time_sync)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one serial cycle: check outputs at negedge, then drive the next edge
  task automatic cyc(input bit stb, input bit en, input bit clr, input string tag);
    logic [3:0] b;
    int nch, s, ch;
    logic ed, es;
    @(negedge clk);
    nch = (sel_snap == 2'b11) ? 4 : ((sel_snap == 2'b00) ? 1 : 2);
    if (since < 16 * nch) begin
      s  = since / 16;
      ch = (s == 0) ? 0 : ((sel_snap == 2'b11) ? s : ((sel_snap == 2'b01) ? 1 : 2));
      ed = snap[ch][since % 16];
      es = ((since % 16) == 0);
      chk({tag, " R2/R3/R4/R11 ser_data"}, ser_data, ed);
    end else begin
      ed = 1'b0;
      es = 1'b0;
      chk({tag, " R5 idle ser_data"}, ser_data, ed);
    end
    chk({tag, " R6 data_sync"}, data_sync, es);
    chk({tag, " R7/R8 time_sync"}, time_sync, exp_ts);

    b = 4'($urandom);
    smp_valid  = stb;
    smp_bits   = b;
    stream_en  = en;
    stream_clr = clr;

    exp_ts = 1'b0;
    if (clr) begin
      idx = 0; tc = 0; since = 100000;
    end else begin
      if (since < 100000) since++;
      if (stb && en) begin
        for (int c = 0; c < 4; c++) cur[c][idx] = b[c];
        if (idx == 15) begin
          for (int c = 0; c < 4; c++) snap[c] = cur[c];
          sel_snap = chan_sel;
          since = 0;
          idx = 0;
        end else begin
          idx++;
        end
        tc++;
        if (tc == per_eff) begin
          tc = 0;
          exp_ts = 1'b1;
        end
      end
    end
  endtask

  task automatic run(input int n, input int k, input logic [1:0] sel, input bit gap, input string tag);
    chan_sel = sel;
    for (int c = 0; c < n; c++)
      cyc((c % k) == 0, !(gap && (c % 53) >= 40), 1'b0, tag);
  endtask

  task automatic clear_now(input string tag);
    cyc(1'b1, 1'b1, 1'b1, {tag, " R9 clear with strobe"});
    cyc(1'b0, 1'b1, 1'b0, {tag, " R9 after clear"});
  endtask

  task automatic set_period(input int p);
    ts_period = 15'(p);
    per_eff = (p < 128) ? 128 : ((p > 16384) ? 16384 : p);
    clear_now("R8 period change");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin cur[c] = '0; snap[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ser_data", ser_data, 1'b0);
    chk("R1 reset data_sync", data_sync, 1'b0);
    chk("R1 reset time_sync", time_sync, 1'b0);

    set_period(128);
    run(2000, 4, 2'b11, 1'b0, "R2 four-channel");
    run(1500, 4, 2'b11, 1'b1, "R10 enable gaps");
    set_period(100);                        // R8: clamps to 128
    run(1500, 2, 2'b01, 1'b0, "R4 I pair");
    run(1500, 2, 2'b10, 1'b0, "R4 signs");  // select change without clear
    run(37, 4, 2'b11, 1'b0, "R9 pre-clear");
    clear_now("R9 mid-slice");
    run(800, 4, 2'b11, 1'b0, "R9 post-clear");
    run(600, 1, 2'b11, 1'b0, "R11 overrun");
    set_period(20000);                      // R8: clamps to 16384
    run(16600, 1, 2'b00, 1'b0, "R8 max period");
    run(200, 3, 2'b01, 1'b1, "R5 tail");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule